// File: doc/BRIEF.md
# Descriptor-Driven Single-Channel DMA Engine

This block runs one DMA channel from a transfer descriptor. Software loads the descriptor while the engine is idle and then arms the channel. Each pulse on the hardware request input runs one minor loop. A minor loop moves a fixed number of bytes as a series of transfer units. The size of each unit is a power of two, from 4 to 32 bytes. Every unit is gathered from the source as back-to-back 32-bit reads and then written to the destination as one wide write.

After each unit the source pointer moves by a signed step. A nonzero wrap field freezes the upper source address bits, so the source can circle through a small register window, such as a bank of capture buffers, while the destination advances linearly through memory. At the end of each minor loop a major-iteration counter counts down. When it expires, the end-of-major adjustments are added to both pointers, the counter reloads and a sticky done flag is raised. The channel can optionally disarm itself at that point, so each frame must be re-armed.

A descriptor that the engine cannot execute is rejected when a request arrives: the engine raises an error and moves no data.

Top module: `dma_desc_engine`

## Requirements
- R1: `desc_xfer_code` selects the unit size as 2^code bytes: 2 gives 4 bytes, 3 gives 8, 4 gives 16 and 5 gives 32. A code below 2 or above the `MAX_CODE` parameter (default 5) is a configuration error.
- R2: A unit of S bytes is read as S/4 reads, one per cycle, with `rd_en` high. The read addresses start at the source pointer and rise in steps of 4, under the same wrap rule as R4. `rd_data` arrives one cycle after `rd_en`. The word from read k occupies `wr_data[32k+31:32k]`. After the last read comes exactly one write cycle, with `wr_code` equal to the code. Bytes of `wr_data` above S are undefined.
- R3: After each unit the source pointer advances by the signed `desc_src_step`. A step of 0 keeps it fixed.
- R4: When `desc_src_wrap` = m is nonzero, only the low m bits of the source address change and the upper bits stay frozen. The address therefore wraps every 2^m bytes.
- R5: After each unit the destination pointer advances by the signed `desc_dst_step`. The first write of a request goes to the current destination pointer.
- R6: An accepted request moves exactly `desc_minor_bytes` bytes, that is minor_bytes/S writes. After that `major_left` decreases by one, unless this was the last iteration.
- R7: When the last major iteration ends, `desc_src_last` is added to the source pointer and `desc_dst_last` to the destination pointer, after their regular step. `major_left` then reloads from `desc_major_count`.
- R8: With `desc_stop_on_major` set, `req_enabled` clears when the major loop completes, and further requests are ignored until `arm` is pulsed. With the bit clear, the channel stays armed.
- R9: A request that finds any of the following raises `cfg_error` and performs no read or write:
  - a source or destination pointer that is not a multiple of S;
  - a step or end adjustment that is not a multiple of S;
  - a minor byte count that is zero or not a multiple of S;
  - a major count of zero;
  - an invalid code.
  The error stays set until the next descriptor load.
- R10: `done` rises when the major loop completes. It stays set until `done_clr` is pulsed, and completion wins over a clear in the same cycle.
- R11: A request made while the channel is not armed, or while a minor loop is running, is ignored. It causes no write and no change to `major_left`.
- R12: After reset the engine is idle, not armed, with `done`, `cfg_error`, `rd_en`, `wr_en` and `major_left` all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_load | input | 1 | Capture the descriptor fields (honoured only when idle) |
| desc_src_addr | input | AW | Initial source pointer |
| desc_src_step | input | OFF_W | Signed source step per unit |
| desc_src_wrap | input | WRAP_W | Source wrap exponent, 0 for none |
| desc_xfer_code | input | 3 | Unit size code, size = 2^code bytes |
| desc_dst_addr | input | AW | Initial destination pointer |
| desc_dst_step | input | OFF_W | Signed destination step per unit |
| desc_minor_bytes | input | NB_W | Bytes per request |
| desc_major_count | input | IT_W | Major iterations per frame |
| desc_src_last | input | AW | Signed source adjustment at major end |
| desc_dst_last | input | AW | Signed destination adjustment at major end |
| desc_stop_on_major | input | 1 | Disarm when the major loop completes |
| arm | input | 1 | Enable hardware requests |
| done_clr | input | 1 | Clear the done flag |
| xfer_req | input | 1 | Hardware request pulse |
| rd_en | output | 1 | Source read strobe |
| rd_addr | output | AW | Source word address |
| rd_data | input | 32 | Source data, valid one cycle after rd_en |
| wr_en | output | 1 | Destination write strobe |
| wr_addr | output | AW | Destination address |
| wr_data | output | 32*2^(MAX_CODE-2) | Assembled unit data |
| wr_code | output | 3 | Size code of the write |
| busy | output | 1 | A minor loop is running |
| done | output | 1 | Sticky major-loop completion flag |
| cfg_error | output | 1 | Sticky descriptor error |
| req_enabled | output | 1 | Channel armed |
| major_left | output | IT_W | Current major iteration count |
| src_ptr | output | AW | Current source pointer |
| dst_ptr | output | AW | Current destination pointer |

## Verification
The embedded properties watch every cycle for the following:
- reads that are not word aligned, or that leave the frozen upper part of the wrap window;
- writes that are not aligned to the unit size, and writes that are not isolated;
- decrement and reload of the iteration counter;
- disarming at major-loop completion;
- the hold of the done flag;
- data movement after a rejected descriptor.

Only the bench scenarios can show that the right words arrive in the right lanes at the right destination in the right order. The same holds for the pointers after the end-of-major adjustments, for the effect of negative steps, and for whether ignored requests truly leave the channel state untouched.

// File: rtl/dma_desc_pkg.sv
package dma_desc_pkg;
   localparam int unsigned WORD_BYTES = 4;
   localparam int unsigned CODE_W     = 3;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_DRAIN = 2'd2,
      ST_WRITE = 2'd3
   } eng_state_e;
endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
   parameter int unsigned AW      = 32,
   parameter int unsigned OFF_W   = 16,
   parameter int unsigned WRAP_W  = 5,
   parameter bit          WRAP_EN = 1'b1
) (
   input  logic [AW-1:0]           base_addr,
   input  logic signed [OFF_W-1:0] step,
   input  logic [WRAP_W-1:0]       wrap_bits,
   output logic [AW-1:0]           next_addr
);
   logic [AW-1:0] step_ext;
   logic [AW-1:0] sum;

   assign step_ext = {{(AW-OFF_W){step[OFF_W-1]}}, step};
   assign sum      = base_addr + step_ext;

   generate
      if (WRAP_EN) begin : g_wrap
         logic [AW-1:0] low_mask;
         assign low_mask  = (AW'(1) << wrap_bits) - AW'(1);
         assign next_addr = (wrap_bits == '0) ? sum
                          : ((base_addr & ~low_mask) | (sum & low_mask));
      end else begin : g_linear
         logic unused_wrap;
         assign unused_wrap = ^wrap_bits;
         assign next_addr   = sum;
      end
   endgenerate
endmodule

// File: rtl/dma_beat_pack.sv
module dma_beat_pack #(
   parameter int unsigned BEATS = 8,
   parameter int unsigned IDX_W = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cap_en,
   input  logic [IDX_W-1:0]      cap_idx,
   input  logic [31:0]           cap_word,
   output logic [BEATS*32-1:0]   packed_data
);
   generate
      for (genvar g = 0; g < BEATS; g++) begin : g_lane
         logic [31:0] lane_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               lane_q <= '0;
            else if (cap_en && (cap_idx == IDX_W'(g)))
               lane_q <= cap_word;
         end
         assign packed_data[g*32 +: 32] = lane_q;
      end
   endgenerate
endmodule

// File: rtl/dma_loop_ctrl.sv
module dma_loop_ctrl #(
   parameter int unsigned NB_W = 16,
   parameter int unsigned IT_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            desc_load,
   input  logic [IT_W-1:0] major_init,
   input  logic            arm,
   input  logic            done_clr,
   input  logic            stop_on_major,
   input  logic            minor_start,
   input  logic [NB_W-1:0] minor_bytes,
   input  logic            unit_done,
   input  logic [NB_W-1:0] unit_bytes,
   output logic            minor_end,
   output logic            major_end,
   output logic [IT_W-1:0] major_left,
   output logic            done,
   output logic            req_en
);
   logic [NB_W-1:0] left_q;
   logic [IT_W-1:0] citer_q;
   logic [IT_W-1:0] biter_q;
   logic            done_q;
   logic            req_q;

   assign minor_end  = unit_done && (left_q == unit_bytes);
   assign major_end  = minor_end && (citer_q == IT_W'(1));
   assign major_left = citer_q;
   assign done       = done_q;
   assign req_en     = req_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q  <= '0;
         citer_q <= '0;
         biter_q <= '0;
         done_q  <= 1'b0;
         req_q   <= 1'b0;
      end else begin
         if (desc_load) begin
            biter_q <= major_init;
            citer_q <= major_init;
         end else if (major_end) begin
            citer_q <= biter_q;
         end else if (minor_end) begin
            citer_q <= citer_q - IT_W'(1);
         end

         if (minor_start)
            left_q <= minor_bytes;
         else if (unit_done)
            left_q <= left_q - unit_bytes;

         if (major_end)
            done_q <= 1'b1;
         else if (done_clr)
            done_q <= 1'b0;

         if (arm)
            req_q <= 1'b1;
         else if (major_end && stop_on_major)
            req_q <= 1'b0;
      end
   end

   // R6: an intermediate minor loop end counts the major counter down by one
   p_major_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (minor_end && !major_end && !desc_load) |=> (major_left == $past(major_left) - IT_W'(1)));

   // R7: the counter reloads from the initial value at major completion
   p_major_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (major_end && !desc_load) |=> (major_left == biter_q));

   // R8: a self-disarming channel drops its request enable
   p_stop_disarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (major_end && stop_on_major && !arm) |=> !req_en);

   // R10: done holds until cleared
   p_done_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !done_clr) |=> done);
endmodule

// File: rtl/dma_desc_engine.sv
module dma_desc_engine
   import dma_desc_pkg::*;
#(
   parameter int unsigned AW          = 32,
   parameter int unsigned OFF_W       = 16,
   parameter int unsigned NB_W        = 16,
   parameter int unsigned IT_W        = 16,
   parameter int unsigned MAX_CODE    = 5,
   parameter bit          SRC_WRAP_EN = 1'b1,
   localparam int unsigned WRAP_W     = $clog2(AW),
   localparam int unsigned BIDX_W     = MAX_CODE - 2,
   localparam int unsigned MAX_BEATS  = 1 << (MAX_CODE - 2),
   localparam int unsigned DATA_W     = 32 * MAX_BEATS
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    desc_load,
   input  logic [AW-1:0]           desc_src_addr,
   input  logic signed [OFF_W-1:0] desc_src_step,
   input  logic [WRAP_W-1:0]       desc_src_wrap,
   input  logic [CODE_W-1:0]       desc_xfer_code,
   input  logic [AW-1:0]           desc_dst_addr,
   input  logic signed [OFF_W-1:0] desc_dst_step,
   input  logic [NB_W-1:0]         desc_minor_bytes,
   input  logic [IT_W-1:0]         desc_major_count,
   input  logic [AW-1:0]           desc_src_last,
   input  logic [AW-1:0]           desc_dst_last,
   input  logic                    desc_stop_on_major,
   input  logic                    arm,
   input  logic                    done_clr,
   input  logic                    xfer_req,
   output logic                    rd_en,
   output logic [AW-1:0]           rd_addr,
   input  logic [31:0]             rd_data,
   output logic                    wr_en,
   output logic [AW-1:0]           wr_addr,
   output logic [DATA_W-1:0]       wr_data,
   output logic [CODE_W-1:0]       wr_code,
   output logic                    busy,
   output logic                    done,
   output logic                    cfg_error,
   output logic                    req_enabled,
   output logic [IT_W-1:0]         major_left,
   output logic [AW-1:0]           src_ptr,
   output logic [AW-1:0]           dst_ptr
);
   // ---------------- elaboration checks ----------------
   generate
      if (MAX_CODE < 3 || MAX_CODE > 7) begin : g_chk_code
         $error("MAX_CODE must lie in 3..7");
      end
      if (OFF_W >= AW) begin : g_chk_off
         $error("OFF_W must be narrower than AW");
      end
      if (OFF_W < MAX_CODE + 2) begin : g_chk_beat
         $error("OFF_W too narrow for beat offsets");
      end
      if (NB_W <= MAX_CODE) begin : g_chk_nb
         $error("NB_W must exceed MAX_CODE");
      end
   endgenerate

   // ---------------- descriptor storage ----------------
   eng_state_e              state_q;
   logic [AW-1:0]           src_q, dst_q;
   logic signed [OFF_W-1:0] sstep_q, dstep_q;
   logic [WRAP_W-1:0]       wrap_q;
   logic [CODE_W-1:0]       code_q;
   logic [NB_W-1:0]         nbytes_q;
   logic [AW-1:0]           slast_q, dlast_q;
   logic                    stop_q;
   logic                    err_q;
   logic [BIDX_W-1:0]       beat_q;
   logic                    cap_en_q;
   logic [BIDX_W-1:0]       cap_idx_q;

   logic idle, load_ok, accept, bad_desc, start_ok;
   logic minor_end, major_end, unit_done, req_en;

   assign idle    = (state_q == ST_IDLE);
   assign load_ok = desc_load && idle;
   assign accept  = idle && xfer_req && req_en;

   // ---------------- descriptor validation ----------------
   logic          code_ok;
   logic [AW-1:0] size_m1;
   logic [AW-1:0] sstep_ext, dstep_ext;

   assign code_ok   = (code_q >= CODE_W'(2)) && (code_q <= CODE_W'(MAX_CODE));
   assign size_m1   = (AW'(1) << code_q) - AW'(1);
   assign sstep_ext = {{(AW-OFF_W){sstep_q[OFF_W-1]}}, sstep_q};
   assign dstep_ext = {{(AW-OFF_W){dstep_q[OFF_W-1]}}, dstep_q};

   assign bad_desc = !code_ok
                  || ((src_q     & size_m1) != '0)
                  || ((dst_q     & size_m1) != '0)
                  || ((sstep_ext & size_m1) != '0)
                  || ((dstep_ext & size_m1) != '0)
                  || ((slast_q   & size_m1) != '0)
                  || ((dlast_q   & size_m1) != '0)
                  || (nbytes_q == '0)
                  || ((nbytes_q & size_m1[NB_W-1:0]) != '0)
                  || (major_left == '0);

   assign start_ok = accept && !bad_desc;

   // ---------------- address generation ----------------
   logic signed [OFF_W-1:0] beat_off;
   logic [AW-1:0]           src_next, dst_next;

   assign beat_off = $signed(OFF_W'({beat_q, 2'b00}));

   dma_addr_step #(.AW(AW), .OFF_W(OFF_W), .WRAP_W(WRAP_W), .WRAP_EN(SRC_WRAP_EN)) u_beat_addr (
      .base_addr (src_q),
      .step      (beat_off),
      .wrap_bits (wrap_q),
      .next_addr (rd_addr)
   );

   dma_addr_step #(.AW(AW), .OFF_W(OFF_W), .WRAP_W(WRAP_W), .WRAP_EN(SRC_WRAP_EN)) u_src_step (
      .base_addr (src_q),
      .step      (sstep_q),
      .wrap_bits (wrap_q),
      .next_addr (src_next)
   );

   dma_addr_step #(.AW(AW), .OFF_W(OFF_W), .WRAP_W(WRAP_W), .WRAP_EN(1'b0)) u_dst_step (
      .base_addr (dst_q),
      .step      (dstep_q),
      .wrap_bits (WRAP_W'(0)),
      .next_addr (dst_next)
   );

   // ---------------- beat assembly ----------------
   dma_beat_pack #(.BEATS(MAX_BEATS), .IDX_W(BIDX_W)) u_pack (
      .clk         (clk),
      .rst_n       (rst_n),
      .cap_en      (cap_en_q),
      .cap_idx     (cap_idx_q),
      .cap_word    (rd_data),
      .packed_data (wr_data)
   );

   // ---------------- loop counters ----------------
   logic [NB_W-1:0]   unit_bytes;
   logic [BIDX_W-1:0] beat_last;

   assign unit_bytes = NB_W'(1) << code_q;
   assign beat_last  = BIDX_W'((32'd1 << (code_q - CODE_W'(2))) - 32'd1);
   assign unit_done  = (state_q == ST_WRITE);

   dma_loop_ctrl #(.NB_W(NB_W), .IT_W(IT_W)) u_loops (
      .clk           (clk),
      .rst_n         (rst_n),
      .desc_load     (load_ok),
      .major_init    (desc_major_count),
      .arm           (arm),
      .done_clr      (done_clr),
      .stop_on_major (stop_q),
      .minor_start   (start_ok),
      .minor_bytes   (nbytes_q),
      .unit_done     (unit_done),
      .unit_bytes    (unit_bytes),
      .minor_end     (minor_end),
      .major_end     (major_end),
      .major_left    (major_left),
      .done          (done),
      .req_en        (req_en)
   );

   // ---------------- sequencer ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         src_q     <= '0;
         dst_q     <= '0;
         sstep_q   <= '0;
         dstep_q   <= '0;
         wrap_q    <= '0;
         code_q    <= '0;
         nbytes_q  <= '0;
         slast_q   <= '0;
         dlast_q   <= '0;
         stop_q    <= 1'b0;
         err_q     <= 1'b0;
         beat_q    <= '0;
         cap_en_q  <= 1'b0;
         cap_idx_q <= '0;
      end else begin
         cap_en_q  <= rd_en;
         cap_idx_q <= beat_q;
         unique case (state_q)
            ST_IDLE: begin
               beat_q <= '0;
               if (load_ok) begin
                  src_q    <= desc_src_addr;
                  dst_q    <= desc_dst_addr;
                  sstep_q  <= desc_src_step;
                  dstep_q  <= desc_dst_step;
                  wrap_q   <= desc_src_wrap;
                  code_q   <= desc_xfer_code;
                  nbytes_q <= desc_minor_bytes;
                  slast_q  <= desc_src_last;
                  dlast_q  <= desc_dst_last;
                  stop_q   <= desc_stop_on_major;
                  err_q    <= 1'b0;
               end else if (accept) begin
                  if (bad_desc) err_q <= 1'b1;
                  else          state_q <= ST_READ;
               end
            end
            ST_READ: begin
               if (beat_q == beat_last) state_q <= ST_DRAIN;
               else                     beat_q  <= beat_q + BIDX_W'(1);
            end
            ST_DRAIN: state_q <= ST_WRITE;
            ST_WRITE: begin
               beat_q  <= '0;
               src_q   <= major_end ? (src_next + slast_q) : src_next;
               dst_q   <= major_end ? (dst_next + dlast_q) : dst_next;
               state_q <= minor_end ? ST_IDLE : ST_READ;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign rd_en       = (state_q == ST_READ);
   assign wr_en       = (state_q == ST_WRITE);
   assign wr_addr     = dst_q;
   assign wr_code     = code_q;
   assign busy        = !idle;
   assign cfg_error   = err_q;
   assign req_enabled = req_en;
   assign src_ptr     = src_q;
   assign dst_ptr     = dst_q;

   // ---------------- assertions ----------------
   logic [AW-1:0] frozen_mask;
   assign frozen_mask = ~((AW'(1) << wrap_q) - AW'(1));

   // R2: every source read is a 32-bit word access
   p_rd_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (rd_addr[1:0] == 2'b00));

   // R2: a write stands alone between read bursts
   p_single_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   // R4: reads stay inside the frozen upper window
   p_wrap_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && SRC_WRAP_EN && (wrap_q != '0)) |->
         ((rd_addr & frozen_mask) == (src_ptr & frozen_mask)));

   // R9: destination writes are aligned to the unit size
   p_wr_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ((wr_addr & size_m1) == '0));

   // R9: a rejected descriptor starts no transfer
   p_err_no_move_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_error) |-> (!rd_en && !wr_en && !busy));
endmodule

// File: tb/dma_desc_engine_tb_top.sv
module dma_desc_engine_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 256;

   typedef struct packed {
      logic [31:0] src;
      logic [15:0] soff;
      logic [4:0]  wrap;
      logic [2:0]  code;
      logic [31:0] dst;
      logic [15:0] doff;
      logic [15:0] nbytes;
      logic [15:0] biter;
      logic [31:0] slast;
      logic [31:0] dlast;
      logic        stop;
   } scen_t;

   localparam scen_t SCN [5] = '{
      '{32'h200, 16'd0,    5'd0, 3'd5, 32'h1000, 16'd32, 16'd32, 16'd3, 32'd0,    -32'sd96, 1'b1},
      '{32'h200, 16'd8,    5'd4, 3'd3, 32'h2000, 16'd8,  16'd16, 16'd2, 32'd0,    -32'sd32, 1'b0},
      '{32'h300, 16'd4,    5'd0, 3'd2, 32'h3000, 16'd4,  16'd12, 16'd2, -32'sd24, 32'd0,    1'b1},
      '{32'h410, 16'd16,   5'd5, 3'd4, 32'h4000, 16'd16, 16'd32, 16'd1, 32'd0,    32'd0,    1'b0},
      '{32'h520, 16'hFFF8, 5'd0, 3'd3, 32'h5000, 16'd8,  16'd24, 16'd1, 32'd0,    32'd0,    1'b0}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic desc_load = 0, desc_stop = 0, arm = 0, done_clr = 0, xfer_req = 0;
   logic [31:0] d_src = 0, d_dst = 0, d_slast = 0, d_dlast = 0;
   logic signed [15:0] d_soff = 0, d_doff = 0;
   logic [4:0] d_wrap = 0;
   logic [2:0] d_code = 0;
   logic [15:0] d_nbytes = 0, d_biter = 0;
   logic rd_en, wr_en, busy, done, cfg_error, req_enabled;
   logic [31:0] rd_addr, wr_addr, src_ptr, dst_ptr;
   logic [31:0] rd_data = 0;
   logic [DW-1:0] wr_data;
   logic [2:0] wr_code;
   logic [15:0] major_left;

   dma_desc_engine dut_i (
      .clk(clk), .rst_n(rst_n), .desc_load(desc_load), .desc_src_addr(d_src),
      .desc_src_step(d_soff), .desc_src_wrap(d_wrap), .desc_xfer_code(d_code),
      .desc_dst_addr(d_dst), .desc_dst_step(d_doff), .desc_minor_bytes(d_nbytes),
      .desc_major_count(d_biter), .desc_src_last(d_slast), .desc_dst_last(d_dlast),
      .desc_stop_on_major(desc_stop), .arm(arm), .done_clr(done_clr), .xfer_req(xfer_req),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_code(wr_code), .busy(busy), .done(done), .cfg_error(cfg_error),
      .req_enabled(req_enabled), .major_left(major_left), .src_ptr(src_ptr), .dst_ptr(dst_ptr)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [31:0] mem_word(logic [31:0] a);
      return {~a[15:0], a[15:0]};
   endfunction

   function automatic logic [31:0] wadd(logic [31:0] b, logic [31:0] d, logic [4:0] m);
      logic [31:0] s, k;
      s = b + d;
      if (m == 0) return s;
      k = (32'd1 << m) - 32'd1;
      return (b & ~k) | (s & k);
   endfunction

   // source memory model: one-cycle read latency
   always @(posedge clk) rd_data <= rd_en ? mem_word(rd_addr) : 32'h0;

   // destination write log
   int wcount = 0;
   logic [31:0]   log_addr [256];
   logic [DW-1:0] log_data [256];
   logic [2:0]    log_code [256];
   always @(posedge clk) begin
      if (wr_en) begin
         log_addr[wcount[7:0]] <= wr_addr;
         log_data[wcount[7:0]] <= wr_data;
         log_code[wcount[7:0]] <= wr_code;
         wcount <= wcount + 1;
      end
   end

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic pulse(ref logic s);
      @(negedge clk) s = 1'b1;
      @(negedge clk) s = 1'b0;
   endtask

   task automatic load_desc(input scen_t c);
      @(negedge clk);
      d_src = c.src; d_soff = c.soff; d_wrap = c.wrap; d_code = c.code;
      d_dst = c.dst; d_doff = c.doff; d_nbytes = c.nbytes; d_biter = c.biter;
      d_slast = c.slast; d_dlast = c.dlast; desc_stop = c.stop;
      desc_load = 1'b1;
      @(negedge clk) desc_load = 1'b0;
   endtask

   task automatic request();
      pulse(xfer_req);
      while (busy) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      scen_t c;
      int base;
      repeat (3) @(negedge clk);
      // R12: reset state
      chk(!busy && !done && !cfg_error && !req_enabled, "R12 flags", {busy,done,cfg_error,req_enabled}, 0);
      chk(major_left == 0 && !rd_en && !wr_en, "R12 counter/strobes", major_left, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R11: unarmed request is ignored
      load_desc(SCN[0]);
      base = wcount;
      request();
      chk(wcount == base, "R11 unarmed no write", wcount - base, 0);
      chk(major_left == 3, "R11 unarmed count kept", major_left, 3);

      // table-driven scenarios
      for (int s = 0; s < 5; s++) begin
         logic [31:0] sp, dp, soff_x, doff_x;
         int size, units, nexp, idx;
         c = SCN[s];
         load_desc(c);
         pulse(arm);
         pulse(done_clr);
         size = 1 << c.code;
         units = c.nbytes / size;
         soff_x = {{16{c.soff[15]}}, c.soff};
         doff_x = {{16{c.doff[15]}}, c.doff};
         base = wcount;
         for (int it = 0; it < c.biter; it++) begin
            request();
            if (it < c.biter - 1) begin
               chk(major_left == c.biter - it - 1, "R6 major decrement", major_left, c.biter - it - 1);
               chk(!done, "R10 done before completion", done, 0);
            end
         end
         nexp = c.biter * units;
         chk(wcount - base == nexp, "R6 write count", wcount - base, nexp);
         sp = c.src; dp = c.dst; idx = base;
         for (int it = 0; it < c.biter; it++) begin
            for (int u = 0; u < units; u++) begin
               logic [DW-1:0] exp, msk;
               exp = '0;
               for (int b = 0; b < size / 4; b++)
                  exp[32*b +: 32] = mem_word(wadd(sp, 32'(4*b), c.wrap));
               msk = (size == 32) ? {DW{1'b1}} : ((DW'(1) << (8*size)) - DW'(1));
               chk(log_addr[idx[7:0]] == dp, "R5 dst address", log_addr[idx[7:0]], dp);
               chk(((log_data[idx[7:0]] ^ exp) & msk) == '0, "R2/R3/R4 unit data",
                   log_data[idx[7:0]] & msk, exp);
               chk(log_code[idx[7:0]] == c.code, "R1 write code", log_code[idx[7:0]], c.code);
               idx++;
               sp = wadd(sp, soff_x, c.wrap);
               dp = dp + doff_x;
            end
         end
         sp = sp + c.slast;
         dp = dp + c.dlast;
         chk(src_ptr == sp, "R7 src after major", src_ptr, sp);
         chk(dst_ptr == dp, "R7 dst after major", dst_ptr, dp);
         chk(major_left == c.biter, "R7 reload", major_left, c.biter);
         chk(done, "R10 done set", done, 1);
         chk(req_enabled == !c.stop, "R8 arm state", req_enabled, !c.stop);
         if (c.stop) begin
            base = wcount;
            request();
            chk(wcount == base, "R8 disarmed request ignored", wcount - base, 0);
         end
      end

      // R10: done holds, then clears
      repeat (4) @(negedge clk);
      chk(done, "R10 done held", done, 1);
      pulse(done_clr);
      chk(!done, "R10 done cleared", done, 0);

      // R8: re-arm
      pulse(arm);
      chk(req_enabled, "R8 re-arm", req_enabled, 1);

      // R9: misaligned source
      c = SCN[2]; c.src = 32'h302;
      load_desc(c); pulse(arm);
      base = wcount;
      request();
      chk(cfg_error, "R9 misaligned src error", cfg_error, 1);
      chk(wcount == base && src_ptr == 32'h302, "R9 no transfer", wcount - base, 0);
      // R9: misaligned destination, error cleared by load first
      c = SCN[0]; c.dst = 32'h1010;
      load_desc(c);
      chk(!cfg_error, "R9 load clears error", cfg_error, 0);
      request();
      chk(cfg_error && wcount == base, "R9 misaligned dst error", cfg_error, 1);
      // R1: codes outside range
      c = SCN[2]; c.code = 3'd6; c.src = 32'h0; c.dst = 32'h0; c.nbytes = 16'd64;
      c.soff = 16'd64; c.doff = 16'd64; c.slast = 0; c.dlast = 0;
      load_desc(c); request();
      chk(cfg_error && wcount == base, "R1 code 6 rejected", cfg_error, 1);
      c.code = 3'd1; c.soff = 16'd2; c.doff = 16'd2; c.nbytes = 16'd2;
      load_desc(c); request();
      chk(cfg_error && wcount == base, "R1 code 1 rejected", cfg_error, 1);

      // R11: request during a running minor loop is ignored
      c = SCN[0]; c.biter = 16'd4; c.stop = 1'b0;
      load_desc(c); pulse(arm);
      base = wcount;
      pulse(xfer_req);
      pulse(xfer_req);
      while (busy) @(negedge clk);
      @(negedge clk);
      chk(wcount - base == 1, "R11 busy request ignored", wcount - base, 1);
      chk(major_left == 3, "R11 single decrement", major_left, 3);

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule